// File: doc/BRIEF.md
# Dual Saturating Accumulator with Convergent Rounding

This block holds two independent 40-bit signed accumulators for a fixed-point datapath. Each one carries a 1.31 fractional value in its low 32 bits, with eight guard bits above it. A single 32-bit operand port feeds the lane chosen by a select input. The operation is one of the following:

- hold
- load
- add
- subtract

Results pass through a saturation stage. That stage can be off, so results wrap. It can clamp to the 1.31 range. Or it can clamp only at the full 40-bit (9.31) range.

Every lane keeps two status bits. The first is a guard-bit flag that tracks the stored value. The second is a sticky catastrophic-overflow flag that records any result that left the 40-bit range. The sticky flag stays set until software pulses that lane's clear strobe. Each lane also presents a registered 16-bit rounded view of its accumulator. The rounding mode is conventional (half rounds up) or convergent (half rounds to the value whose least significant bit is zero).

The accumulator, the flags and the rounded word are all registered on the same edge. The outputs therefore always describe one consistent state.

Top module: `dacc_sat_round`

## Requirements
- R1: Op code 1 (load) writes the 32-bit operand into bits 31:0 of the selected accumulator and fills bits 39:32 with operand bit 31. The sticky flag is unchanged.
- R2: Op codes 2 (add) and 3 (subtract) form the accumulator plus or minus the sign-extended operand. With `sat_en` = 0 the result is stored modulo 2^40.
- R3: With `sat_en` = 1 and `sat_super` = 0, an add or subtract whose exact result lies outside [-2^31, 2^31-1] stores 0x00_7FFF_FFFF if the result is positive, or 0xFF_8000_0000 if it is negative.
- R4: With `sat_en` = 1 and `sat_super` = 1, an exact result outside [-2^39, 2^39-1] stores 0x7F_FFFF_FFFF or 0x80_0000_0000. Results inside that range are stored unchanged, even when they lie beyond the 1.31 range.
- R5: `cat_sticky` for a lane goes high on the edge after any add or subtract on that lane whose exact result lies outside the 40-bit signed range. This holds in every saturation setting. The flag stays high until that lane's `clr_sticky` bit is sampled high. If a set and a clear fall in the same cycle, the set wins.
- R6: `guard_flag` is high exactly when bits 39:31 of the stored accumulator are not all equal. It is updated on the same edge as the accumulator.
- R7: With `rnd_conv` = 0, `acc_rnd` equals acc[31:16] plus 1 when acc[15:0] >= 0x8000, and plus 0 otherwise, modulo 2^16.
- R8: With `rnd_conv` = 1, `acc_rnd` equals acc[31:16] plus 1 in two cases: when acc[15:0] > 0x8000, or when acc[15:0] = 0x8000 and acc[16] = 1. The sum is taken modulo 2^16. The mode applies to the value stored on the same edge.
- R9: Only the lane named by `lane_sel` is updated. The other lane, and a lane given op code 0 (hold), keeps its accumulator value.
- R10: While `rst` is high on a clock edge, all accumulators, rounded outputs and flags become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sel | input | LANE_W | Accumulator targeted by `op` |
| op | input | 2 | 0 hold, 1 load, 2 add, 3 subtract |
| operand | input | IN_W | Signed 1.31 operand |
| sat_en | input | 1 | Enables clamping |
| sat_super | input | 1 | With `sat_en`, clamp at the 40-bit limit instead of the 1.31 limit |
| rnd_conv | input | 1 | 1 selects convergent rounding, 0 selects conventional |
| clr_sticky | input | N_ACC | Per-lane clear strobe for the sticky flag |
| acc_val | output | N_ACC x ACC_W | Stored accumulators |
| acc_rnd | output | N_ACC x OUT_W | Rounded view of each accumulator |
| guard_flag | output | N_ACC | Stored value uses the guard bits |
| cat_sticky | output | N_ACC | Sticky 40-bit overflow flag |

## Verification
The sticky flag's set and clear can land in the same cycle. The bench provokes this by pulsing `clr_sticky` during adds that pin a lane against the 40-bit limit in super-saturation. It also pulses the clear on its own, and inside a long random mix of operations. A reference model in the bench applies the same-cycle rule that the set wins and is compared after every edge.

Rounding and saturation also coincide on each update. The rounded word is therefore judged against the clamped value, not the raw sum, across sweeps of edge-case operands in all three saturation settings.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } acc_op_e;
endpackage

// File: rtl/dacc_round.sv
// Rounds the 1.31 part of an accumulator down to OUT_W bits.
module dacc_round #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  frac_in,
  input  logic             conv,
  output logic [OUT_W-1:0] rnd_out
);
  localparam int DROP_W = IN_W - OUT_W;
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic [DROP_W-1:0] low_part;
  logic [OUT_W-1:0]  high_part;
  logic              above_half, at_half, bump;

  always_comb begin
    low_part   = frac_in[DROP_W-1:0];
    high_part  = frac_in[IN_W-1:DROP_W];
    above_half = low_part > HALF;
    at_half    = low_part == HALF;
    // A tie goes up unconditionally in conventional mode; in convergent
    // mode only when the kept LSB is odd, landing on an even result.
    bump       = above_half | (at_half & (~conv | frac_in[DROP_W]));
    rnd_out    = high_part + OUT_W'(bump);
  end
endmodule

// File: rtl/dacc_lane.sv
// One accumulator lane: add/sub, overflow detection, clamping and flags.
module dacc_lane
  import dacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int IN_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  acc_op_e          op,
  input  logic [IN_W-1:0]  operand,
  input  logic             sat_en,
  input  logic             sat_super,
  input  logic             clr_sticky,
  output logic [ACC_W-1:0] acc_d,
  output logic [ACC_W-1:0] acc_q,
  output logic             guard_q,
  output logic             sticky_q
);
  localparam int GRD_W = ACC_W - IN_W;
  localparam int CHK_W = GRD_W + 2;
  localparam logic [ACC_W-1:0] MAX_NORM = {{(GRD_W+1){1'b0}}, {(IN_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_NORM = {{(GRD_W+1){1'b1}}, {(IN_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] op_ext;
  logic [ACC_W:0]   sum_w;
  logic [CHK_W-1:0] sum_top;
  logic             ovf_full, ovf_norm, sum_neg, cat_evt;
  logic [GRD_W:0]   nxt_top;
  logic             guard_d, sticky_d;

  always_comb begin
    op_ext = {{GRD_W{operand[IN_W-1]}}, operand};
    if (op == OP_SUB)
      sum_w = {acc_q[ACC_W-1], acc_q} - {op_ext[ACC_W-1], op_ext};
    else
      sum_w = {acc_q[ACC_W-1], acc_q} + {op_ext[ACC_W-1], op_ext};
    sum_neg  = sum_w[ACC_W];
    ovf_full = sum_w[ACC_W] ^ sum_w[ACC_W-1];
    sum_top  = sum_w[ACC_W:IN_W-1];
    ovf_norm = ~((&sum_top) | ~(|sum_top));

    acc_d   = acc_q;
    cat_evt = 1'b0;
    if (upd) begin
      unique case (op)
        OP_LOAD: acc_d = op_ext;
        OP_ADD, OP_SUB: begin
          cat_evt = ovf_full;
          if (sat_en && sat_super && ovf_full)
            acc_d = sum_neg ? MIN_FULL : MAX_FULL;
          else if (sat_en && !sat_super && ovf_norm)
            acc_d = sum_neg ? MIN_NORM : MAX_NORM;
          else
            acc_d = sum_w[ACC_W-1:0];
        end
        default: acc_d = acc_q;
      endcase
    end

    nxt_top  = acc_d[ACC_W-1:IN_W-1];
    guard_d  = ~((&nxt_top) | ~(|nxt_top));
    // A fresh overflow outranks a clear issued in the same cycle.
    sticky_d = (sticky_q & ~clr_sticky) | cat_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      guard_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      guard_q  <= guard_d;
      sticky_q <= sticky_d;
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (upd && op == OP_LOAD) |=>
      acc_q == {{GRD_W{$past(operand[IN_W-1])}}, $past(operand)}); // R1
  AST_NORM_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (upd && sat_en && !sat_super && (op == OP_ADD || op == OP_SUB)) |=>
      !guard_q); // R3
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && !clr_sticky) |=> sticky_q); // R5
  AST_STICKY_DROP: assert property (@(posedge clk) disable iff (rst)
    (clr_sticky && !upd) |=> !sticky_q); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!upd || op == OP_HOLD) |=> $stable(acc_q)); // R9
endmodule

// File: rtl/dacc_sat_round.sv
// Top: N_ACC accumulator lanes, each with a registered rounded view.
module dacc_sat_round
  import dacc_pkg::*;
#(
  parameter int N_ACC  = 2,
  parameter int ACC_W  = 40,
  parameter int IN_W   = 32,
  parameter int OUT_W  = 16,
  parameter int LANE_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANE_W-1:0]           lane_sel,
  input  logic [1:0]                  op,
  input  logic [IN_W-1:0]             operand,
  input  logic                        sat_en,
  input  logic                        sat_super,
  input  logic                        rnd_conv,
  input  logic [N_ACC-1:0]            clr_sticky,
  output logic [N_ACC-1:0][ACC_W-1:0] acc_val,
  output logic [N_ACC-1:0][OUT_W-1:0] acc_rnd,
  output logic [N_ACC-1:0]            guard_flag,
  output logic [N_ACC-1:0]            cat_sticky
);
  localparam int RND_LSB = IN_W - OUT_W;

  acc_op_e op_e;
  assign op_e = acc_op_e'(op);

  for (genvar g = 0; g < N_ACC; g++) begin : g_lane
    logic [ACC_W-1:0] nxt_acc;
    logic [OUT_W-1:0] rnd_d;
    logic [OUT_W-1:0] rnd_q;
    logic             hit;

    assign hit = (lane_sel == LANE_W'(g));

    dacc_lane #(.ACC_W(ACC_W), .IN_W(IN_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .upd       (hit),
      .op        (op_e),
      .operand   (operand),
      .sat_en    (sat_en),
      .sat_super (sat_super),
      .clr_sticky(clr_sticky[g]),
      .acc_d     (nxt_acc),
      .acc_q     (acc_val[g]),
      .guard_q   (guard_flag[g]),
      .sticky_q  (cat_sticky[g])
    );

    dacc_round #(.IN_W(IN_W), .OUT_W(OUT_W)) u_round (
      .frac_in(nxt_acc[IN_W-1:0]),
      .conv   (rnd_conv),
      .rnd_out(rnd_d)
    );

    always_ff @(posedge clk) begin
      if (rst) rnd_q <= '0;
      else     rnd_q <= rnd_d;
    end
    assign acc_rnd[g] = rnd_q;

    AST_RND_STEP: assert property (@(posedge clk) disable iff (rst)
      ((OUT_W'(rnd_q - acc_val[g][IN_W-1:RND_LSB])) <= OUT_W'(1))); // R7
  end
endmodule

// File: tb/dacc_sat_round_tb_top.sv
module dacc_sat_round_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint MAX40 = (longint'(1) <<< 39) - 1;
  localparam longint MIN40 = -(longint'(1) <<< 39);
  localparam longint MAX32 = (longint'(1) <<< 31) - 1;
  localparam longint MIN32 = -(longint'(1) <<< 31);

  logic clk = 1'b0;
  logic rst;
  logic [0:0] lane_sel;
  logic [1:0] op;
  logic [31:0] operand;
  logic sat_en, sat_super, rnd_conv;
  logic [1:0] clr_sticky;
  logic [1:0][39:0] acc_val;
  logic [1:0][15:0] acc_rnd;
  logic [1:0] guard_flag, cat_sticky;

  int n_chk = 0;
  int n_fail = 0;
  longint m_acc[2];
  bit m_stk[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dacc_sat_round dut_i (
    .clk(clk), .rst(rst), .lane_sel(lane_sel), .op(op), .operand(operand),
    .sat_en(sat_en), .sat_super(sat_super), .rnd_conv(rnd_conv),
    .clr_sticky(clr_sticky), .acc_val(acc_val), .acc_rnd(acc_rnd),
    .guard_flag(guard_flag), .cat_sticky(cat_sticky)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int lane, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s lane%0d %s got %h exp %h", tag, lane, what, got, exp);
    end
  endtask

  function automatic longint wrap40(input longint v);
    logic [63:0] u;
    u = v;
    u = {{24{u[39]}}, u[39:0]};
    return longint'(u);
  endfunction

  function automatic logic [31:0] edge_val(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;  3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'h4000_0000;
      6: return 32'hC000_0000;  7: return 32'h3FFF_FFFF;
      8: return 32'h7FFF_8000;  9: return 32'h0000_8000;
      10: return 32'h8000_0001; 11: return 32'h1234_5678;
      12: return 32'hFFFF_0000; 13: return 32'h0001_0000;
      14: return 32'h7FFF_FFFE; default: return 32'hBFFF_FFFF;
    endcase
  endfunction

  // Model update for one lane.
  task automatic ref_step(input int l, input bit hit, input logic [1:0] o,
                          input logic [31:0] v, input bit se, input bit sup,
                          input bit clr);
    longint ext, sum;
    bit evt;
    ext = longint'(signed'(v));
    evt = 1'b0;
    if (hit && o == 2'd1) m_acc[l] = ext;
    else if (hit && (o == 2'd2 || o == 2'd3)) begin
      sum = (o == 2'd2) ? m_acc[l] + ext : m_acc[l] - ext;
      evt = (sum > MAX40) || (sum < MIN40);
      if (se && sup && evt) m_acc[l] = (sum < 0) ? MIN40 : MAX40;
      else if (se && !sup && (sum > MAX32 || sum < MIN32))
        m_acc[l] = (sum < 0) ? MIN32 : MAX32;
      else m_acc[l] = wrap40(sum);
    end
    m_stk[l] = (m_stk[l] & !clr) | evt;
  endtask

  task automatic compare(input int l, input string tag, input bit conv);
    logic [63:0] u;
    logic [15:0] lo, hi, exp_rnd;
    bit inc, exp_grd;
    u = m_acc[l];
    lo = u[15:0];
    hi = u[31:16];
    if (conv) inc = (lo > 16'h8000) || (lo == 16'h8000 && u[16]);
    else      inc = (lo >= 16'h8000);
    exp_rnd = hi + 16'(inc);
    exp_grd = (m_acc[l] > MAX32) || (m_acc[l] < MIN32);
    chk(acc_val[l] == u[39:0], tag, "acc", l, longint'(acc_val[l]), longint'(u[39:0]));
    chk(acc_rnd[l] == exp_rnd, conv ? "R8" : "R7", "rnd", l,
        longint'(acc_rnd[l]), longint'(exp_rnd));
    chk(guard_flag[l] == exp_grd, "R6", "guard", l,
        longint'(guard_flag[l]), longint'(exp_grd));
    chk(cat_sticky[l] == m_stk[l], "R5", "sticky", l,
        longint'(cat_sticky[l]), longint'(m_stk[l]));
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(input int lane, input logic [1:0] o, input logic [31:0] v,
                      input bit se, input bit sup, input bit conv,
                      input bit [1:0] clr, input string tag);
    lane_sel = 1'(lane); op = o; operand = v;
    sat_en = se; sat_super = sup; rnd_conv = conv; clr_sticky = clr;
    for (int l = 0; l < 2; l++) ref_step(l, l == lane, o, v, se, sup, clr[l]);
    @(negedge clk);
    for (int l = 0; l < 2; l++) compare(l, (l == lane) ? tag : "R9", conv);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; lane_sel = '0; op = 2'd0; operand = '0;
    sat_en = 1'b0; sat_super = 1'b0; rnd_conv = 1'b0; clr_sticky = '0;
    for (int l = 0; l < 2; l++) begin m_acc[l] = 0; m_stk[l] = 1'b0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    for (int l = 0; l < 2; l++) begin
      chk(acc_val[l] == '0 && acc_rnd[l] == '0 && guard_flag[l] == 1'b0 &&
          cat_sticky[l] == 1'b0, "R10", "reset", l, longint'(acc_val[l]), 0);
    end
    rst = 1'b0;

    // R7/R8: rounding sweep over loaded values, both modes
    for (int i = 0; i < 2048; i++) begin
      logic [31:0] v;
      v = {16'(i * 113), 16'(i * 37)};
      step(i % 2, 2'd1, v, 1'b0, 1'b0, bit'(i[0] ^ i[1]), 2'b00, "R1");
    end
    // R7/R8: exact ties and their neighbours, odd and even kept LSB
    for (int h = 0; h < 4; h++) begin
      for (int k = 0; k < 3; k++) begin
        for (int c = 0; c < 2; c++) begin
          logic [15:0] hv, lv;
          hv = (h == 0) ? 16'h1234 : (h == 1) ? 16'h1235 : (h == 2) ? 16'h7FFF : 16'hFFFF;
          lv = 16'h7FFF + 16'(k);
          step(h % 2, 2'd1, {hv, lv}, 1'b0, 1'b0, bit'(c), 2'b00, c ? "R8" : "R7");
        end
      end
    end

    // R2/R3/R4: edge operand sweep in every saturation setting
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int s = 0; s < 2; s++) begin
            string t;
            bit se, sup;
            se = (m != 0); sup = (m == 2);
            t = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
            step(b % 2, 2'd1, edge_val(a), se, sup, 1'b1, 2'b00, "R1");
            step(b % 2, 2'd2, edge_val(a), se, sup, 1'b0, 2'b00, t);
            step(b % 2, s ? 2'd3 : 2'd2, edge_val(b), se, sup, 1'b1, 2'b00, t);
          end
        end
      end
    end

    // R2 and R5: long positive run with wrap past the 40-bit limit
    step(0, 2'd1, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 2'b11, "R1");
    for (int i = 0; i < 300; i++)
      step(0, 2'd2, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 2'b00, "R2");
    step(1, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b01, "R5");

    // R4 and R5: pin lane 1 against the limit, clear during overflow
    step(1, 2'd1, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 2'b00, "R1");
    for (int i = 0; i < 300; i++)
      step(1, 2'd2, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b1,
           (i > 290) ? 2'b10 : 2'b00, "R4");
    step(1, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0, 2'b10, "R5");
    step(1, 2'd3, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 2'b10, "R5");
    for (int i = 0; i < 600; i++)
      step(1, 2'd3, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 2'b00, "R4");

    // R9: random mix of lanes, ops, modes and clears
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] v;
      int r;
      r = int'($urandom_range(0, 15));
      v = (r < 8) ? edge_val(r * 2) : $urandom;
      step(int'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), v,
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)),
           ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
           "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule